// File: doc/BRIEF.md
# Line-Tripled VGA Framebuffer Scanout

This block produces 800x600, 56 Hz VGA timing from a system clock running at twice the pixel rate. It streams a low-resolution framebuffer that holds one byte per pixel onto a 3-bit colour output. Each stored row is shown on three consecutive display lines, so 200 stored rows fill the 600 visible lines. Each byte is held for nine system clocks, which gives wide, coarse pixels. Each stored row has three trailing padding bytes, and these bytes are streamed like any other.

The framebuffer sits outside the block behind a synchronous read port with one cycle of latency. The block issues a read address with a read strobe, one strobe per byte. A per-frame start offset is added to a fixed base address when the frame's scan window opens. The timing constants are all parameters, so a scaled-down frame can be exercised quickly.

Top module: `line3_vga_scanout`

## Requirements
- R1: A display line lasts LINE_CLKS clocks (default 2048). hsync is in its active level for the first HSYNC_CLKS clocks of each line (default 144) and inactive for the rest. The active level is low when HS_ACTIVE_LOW is 1 (the default).
- R2: A frame lasts FRAME_LINES lines (default 625). vsync is high for the first VSYNC_LINES lines of the frame (default 2) and low otherwise. vsync never changes except at a line boundary.
- R3: The scan window opens at the start of line WIN_LINE (default 24). Pixels are read and streamed only on lines inside the window.
- R4: Each stored row is streamed on REPEAT (3) consecutive window lines. After the third line the row address advances by one stride.
- R5: The stride is FB_WIDTH + 3 bytes. Every stride byte, padding included, is read and shown on every streamed line, in ascending address order.
- R6: The read port returns data one cycle after rd_en. rd_en pulses once per byte: first at line clock STREAM_START-2, then every HOLD_CLKS (default 9) clocks. rd_en is never high on two consecutive clocks.
- R7: Byte k of a line drives rgb from line clock STREAM_START + k*HOLD_CLKS (default STREAM_START 360) for HOLD_CLKS clocks. rgb[0] is red, rgb[1] is green and rgb[2] is blue, taken from bits 0, 1 and 2 of the byte.
- R8: rgb is 000 whenever no byte is being streamed: during sync, the porches, and after the last stride byte.
- R9: After FB_ROWS rows have each been shown three times, the window closes. The next window restarts at BASE_ADDR + offset, where offset is sampled only on the clock that opens the window. A change to offset at any other time has no effect.
- R10: While rst_n is low, hsync is active, vsync is high, rgb is 000 and rd_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| offset | input | ADDR_W | Frame start offset added to BASE_ADDR at window open |
| rd_en | output | 1 | Framebuffer read strobe |
| rd_addr | output | ADDR_W | Framebuffer read address, valid with rd_en |
| rd_data | input | 8 | Read data, valid one cycle after rd_en |
| hsync | output | 1 | Horizontal sync, polarity set by HS_ACTIVE_LOW |
| vsync | output | 1 | Vertical sync, active high |
| rgb | output | 3 | Colour lines: bit 0 red, bit 1 green, bit 2 blue |

## Verification
A wrong horizontal or vertical counter shows up as a sync edge in the wrong clock, so it is caught on the first line or frame where it happens. A bad repeat or row counter shows up as a wrong rd_addr at the first strobe of the following line. A stale base or a sampled offset shows up at the first read of the window. An off-by-one in the fetch pipeline moves an rgb transition by a clock, and the per-clock comparison reports it at the first pixel of the first streamed line.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;
  // counter width for a count range of n, at least one bit
  function automatic int cw(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/vgs_timing.sv
module vgs_timing
  import vga_scan_pkg::*;
#(
  parameter int LINE_CLKS     = 2048,
  parameter int HSYNC_CLKS    = 144,
  parameter int STREAM_START  = 360,
  parameter int FRAME_LINES   = 625,
  parameter int VSYNC_LINES   = 2,
  parameter int WIN_LINE      = 24,
  parameter bit HS_ACTIVE_LOW = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [cw(LINE_CLKS)-1:0]      hcnt,
  output logic [cw(FRAME_LINES)-1:0]    vcnt,
  output logic                          hsync,
  output logic                          vsync,
  output logic                          win_open,
  output logic                          fetch_go
);
  localparam int HW = cw(LINE_CLKS);
  localparam int VW = cw(FRAME_LINES);
  localparam logic [HW-1:0] H_LAST  = HW'(LINE_CLKS - 1);
  localparam logic [HW-1:0] H_SYNC  = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] H_GO    = HW'(STREAM_START - 3);
  localparam logic [VW-1:0] V_LAST  = VW'(FRAME_LINES - 1);
  localparam logic [VW-1:0] V_SYNC  = VW'(VSYNC_LINES);
  localparam logic [VW-1:0] V_PREW  = VW'(WIN_LINE - 1);

  logic [HW-1:0] hcnt_d;
  logic [VW-1:0] vcnt_d;
  logic          h_end;
  logic          hs_act;

  always_comb begin
    h_end  = (hcnt == H_LAST);
    hcnt_d = h_end ? '0 : hcnt + 1'b1;
    vcnt_d = vcnt;
    if (h_end) begin
      vcnt_d = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hcnt_d;
      vcnt <= vcnt_d;
    end
  end

  always_comb begin
    hs_act   = (hcnt < H_SYNC);
    hsync    = HS_ACTIVE_LOW ? ~hs_act : hs_act;
    vsync    = (vcnt < V_SYNC);
    win_open = h_end && (vcnt == V_PREW);
    fetch_go = (hcnt == H_GO);
  end

  // R2
  vsync_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != '0) |-> $stable(vsync));
endmodule

// File: rtl/vgs_rowseq.sv
module vgs_rowseq
  import vga_scan_pkg::*;
#(
  parameter int FB_WIDTH  = 100,
  parameter int FB_ROWS   = 200,
  parameter int PAD_BYTES = 3,
  parameter int REPEAT    = 3,
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_open,
  input  logic              line_done,
  input  logic [ADDR_W-1:0] offset,
  output logic              scan_en,
  output logic [ADDR_W-1:0] row_ptr
);
  localparam int STRIDE = FB_WIDTH + PAD_BYTES;
  localparam int PW     = cw(REPEAT);
  localparam int RW     = cw(FB_ROWS);
  localparam logic [PW-1:0]     REP_LAST = PW'(REPEAT - 1);
  localparam logic [RW-1:0]     ROW_LAST = RW'(FB_ROWS - 1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BASE_ADDR);

  logic              en_q,  en_d;
  logic [PW-1:0]     rep_q, rep_d;
  logic [RW-1:0]     row_q, row_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    en_d  = en_q;
    rep_d = rep_q;
    row_d = row_q;
    ptr_d = ptr_q;
    if (win_open) begin
      en_d  = 1'b1;
      rep_d = '0;
      row_d = '0;
      ptr_d = BASE + offset;
    end else if (line_done && en_q) begin
      if (rep_q == REP_LAST) begin
        rep_d = '0;
        if (row_q == ROW_LAST) begin
          row_d = '0;
          en_d  = 1'b0;
        end else begin
          row_d = row_q + 1'b1;
          ptr_d = ptr_q + STEP;
        end
      end else begin
        rep_d = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rep_q <= '0;
      row_q <= '0;
      ptr_q <= '0;
    end else begin
      en_q  <= en_d;
      rep_q <= rep_d;
      row_q <= row_d;
      ptr_q <= ptr_d;
    end
  end

  assign scan_en = en_q;
  assign row_ptr = ptr_q;

  // R3
  line_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> scan_en);
endmodule

// File: rtl/vgs_fetch.sv
module vgs_fetch
  import vga_scan_pkg::*;
#(
  parameter int FB_WIDTH  = 100,
  parameter int PAD_BYTES = 3,
  parameter int HOLD_CLKS = 9,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_go,
  input  logic              scan_en,
  input  logic [ADDR_W-1:0] row_ptr,
  input  logic [7:0]        rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [2:0]        rgb,
  output logic              line_done
);
  localparam int NB = FB_WIDTH + PAD_BYTES;
  localparam int BW = cw(NB);
  localparam int TW = cw(HOLD_CLKS);
  localparam logic [BW-1:0] B_LAST = BW'(NB - 1);
  localparam logic [TW-1:0] T_LAST = TW'(HOLD_CLKS - 1);

  logic          busy_q, busy_d;
  logic [BW-1:0] idx_q,  idx_d;
  logic [TW-1:0] tick_q, tick_d;
  logic          busy_p1, rden_p1;
  logic [2:0]    pix_q,  pix_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    tick_d = tick_q;
    if (!busy_q) begin
      if (fetch_go && scan_en) begin
        busy_d = 1'b1;
        idx_d  = '0;
        tick_d = '0;
      end
    end else if (tick_q == T_LAST) begin
      tick_d = '0;
      if (idx_q == B_LAST) begin
        busy_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_comb begin
    rd_en     = busy_q && (tick_q == '0);
    rd_addr   = row_ptr + ADDR_W'(idx_q);
    line_done = busy_q && (tick_q == T_LAST) && (idx_q == B_LAST);
    pix_d     = '0;
    if (busy_p1) begin
      pix_d = rden_p1 ? rd_data[2:0] : pix_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      tick_q  <= '0;
      busy_p1 <= 1'b0;
      rden_p1 <= 1'b0;
      pix_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      tick_q  <= tick_d;
      busy_p1 <= busy_q;
      rden_p1 <= rd_en;
      pix_q   <= pix_d;
    end
  end

  assign rgb = pix_q;

  generate
    if (HOLD_CLKS > 1) begin : g_gap
      // R6
      read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    end
  endgenerate
endmodule

// File: rtl/line3_vga_scanout.sv
module line3_vga_scanout
  import vga_scan_pkg::*;
#(
  parameter int LINE_CLKS     = 2048,
  parameter int HSYNC_CLKS    = 144,
  parameter int STREAM_START  = 360,
  parameter int FRAME_LINES   = 625,
  parameter int VSYNC_LINES   = 2,
  parameter int WIN_LINE      = 24,
  parameter int FB_WIDTH      = 100,
  parameter int FB_ROWS       = 200,
  parameter int PAD_BYTES     = 3,
  parameter int REPEAT        = 3,
  parameter int HOLD_CLKS     = 9,
  parameter int ADDR_W        = 16,
  parameter int BASE_ADDR     = 0,
  parameter bit HS_ACTIVE_LOW = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] offset,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              hsync,
  output logic              vsync,
  output logic [2:0]        rgb
);
  localparam int HW = cw(LINE_CLKS);
  localparam int VW = cw(FRAME_LINES);
  localparam logic [HW-1:0] H_SYNC   = HW'(HSYNC_CLKS);
  localparam logic [HW-1:0] H_START  = HW'(STREAM_START);
  localparam logic [VW-1:0] V_OPEN   = VW'(WIN_LINE);
  localparam logic [VW-1:0] V_CLOSE  = VW'(WIN_LINE + FB_ROWS * REPEAT - 1);

  logic [HW-1:0]     hcnt;
  logic [VW-1:0]     vcnt;
  logic              win_open, fetch_go, scan_en, line_done;
  logic [ADDR_W-1:0] row_ptr;

  vgs_timing #(
    .LINE_CLKS(LINE_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .STREAM_START(STREAM_START),
    .FRAME_LINES(FRAME_LINES), .VSYNC_LINES(VSYNC_LINES), .WIN_LINE(WIN_LINE),
    .HS_ACTIVE_LOW(HS_ACTIVE_LOW)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync),
    .vsync(vsync), .win_open(win_open), .fetch_go(fetch_go)
  );

  vgs_rowseq #(
    .FB_WIDTH(FB_WIDTH), .FB_ROWS(FB_ROWS), .PAD_BYTES(PAD_BYTES),
    .REPEAT(REPEAT), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_rowseq (
    .clk(clk), .rst_n(rst_n), .win_open(win_open), .line_done(line_done),
    .offset(offset), .scan_en(scan_en), .row_ptr(row_ptr)
  );

  vgs_fetch #(
    .FB_WIDTH(FB_WIDTH), .PAD_BYTES(PAD_BYTES), .HOLD_CLKS(HOLD_CLKS),
    .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .scan_en(scan_en),
    .row_ptr(row_ptr), .rd_data(rd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rgb(rgb), .line_done(line_done)
  );

  // R8
  blank_in_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < H_SYNC) |-> (rgb == 3'b000));

  // R7
  no_early_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb != 3'b000) |-> (hcnt >= H_START));

  // R3
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> (vcnt == V_OPEN && hcnt == '0));

  // R9
  window_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scan_en) |-> (vcnt == V_CLOSE));
endmodule

// File: tb/line3_vga_scanout_bench.sv
module line3_vga_scanout_bench;
  localparam int LC = 128;
  localparam int HS = 10;
  localparam int SS = 24;
  localparam int FL = 20;
  localparam int VS = 2;
  localparam int WL = 4;
  localparam int FW = 8;
  localparam int FR = 4;
  localparam int RP = 3;
  localparam int HD = 9;
  localparam int AW = 10;
  localparam int BA = 16;
  localparam int NB = FW + 3;
  localparam int NFRAMES = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] offset;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic          hsync, vsync;
  logic [2:0]    rgb;

  logic [7:0] mem [0:(1<<AW)-1];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  line3_vga_scanout #(
    .LINE_CLKS(LC), .HSYNC_CLKS(HS), .STREAM_START(SS), .FRAME_LINES(FL),
    .VSYNC_LINES(VS), .WIN_LINE(WL), .FB_WIDTH(FW), .FB_ROWS(FR),
    .PAD_BYTES(3), .REPEAT(RP), .HOLD_CLKS(HD), .ADDR_W(AW), .BASE_ADDR(BA),
    .HS_ACTIVE_LOW(1'b1)
  ) u_line3_vga_scanout (
    .clk(clk), .rst_n(rst_n), .offset(offset), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync(hsync), .vsync(vsync),
    .rgb(rgb)
  );

  // framebuffer model: one cycle read latency, output held when idle
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  task automatic chk(input string tag, input int act, input int exp,
                     input string what, input int t);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at t=%0d", tag, what, act, exp, t);
    end
  endtask

  function automatic int frame_off(int f);
    return (f == 0) ? 0 : ((f == 1) ? 37 : 100);
  endfunction

  initial begin
    int base_lat;
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'((i * 37 + 11) % 256);
    rd_data = 8'h00;
    offset  = AW'(frame_off(0));
    rst_n   = 1'b0;
    base_lat = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", int'(hsync), 0, "hsync in reset", -1);
    chk("R10", int'(vsync), 1, "vsync in reset", -1);
    chk("R10", int'(rgb),   0, "rgb in reset",   -1);
    chk("R10", int'(rd_en), 0, "rd_en in reset", -1);
    rst_n = 1'b1;
    for (int t = 0; t < NFRAMES * FL * LC; t++) begin
      int h, v, f, row, ra, rk;
      bit act;
      #1;
      h = t % LC;
      v = (t / LC) % FL;
      f = t / (LC * FL);
      act = (v >= WL) && (v < WL + FR * RP);
      row = act ? (v - WL) / RP : 0;
      // R1 horizontal sync, active low
      chk("R1", int'(hsync), (h < HS) ? 0 : 1, "hsync", t);
      // R2 vertical sync, active high
      chk("R2", int'(vsync), (v < VS) ? 1 : 0, "vsync", t);
      // R6 read strobe schedule
      ra = h - (SS - 2);
      rk = (ra >= 0) ? ra / HD : 0;
      if (act && ra >= 0 && (ra % HD) == 0 && rk < NB) begin
        chk("R6", int'(rd_en), 1, "rd_en", t);
        if (row == 0 && rk == 0)
          chk("R9", int'(rd_addr), base_lat, "first address of window", t);
        else if (rk >= FW)
          chk("R5", int'(rd_addr), base_lat + row * NB + rk, "padding address", t);
        else
          chk("R4", int'(rd_addr), base_lat + row * NB + rk, "row address", t);
      end else begin
        chk(act ? "R6" : "R3", int'(rd_en), 0, "rd_en idle", t);
      end
      // R7 / R8 / R3 colour output
      if (act && h >= SS && h < SS + NB * HD) begin
        int a;
        a = base_lat + row * NB + (h - SS) / HD;
        chk("R7", int'(rgb), int'(mem[a][2:0]), "rgb pixel", t);
      end else begin
        chk(act ? "R8" : "R3", int'(rgb), 0, "rgb blank", t);
      end
      // stimulus: new offset each frame, garbage offset inside window (R9)
      if (h == 0 && v == 0) offset = AW'(frame_off(f));
      if (h == 7 && v == WL + 2) offset = AW'(10'h3A5);
      if (h == LC - 1 && v == WL - 1) base_lat = BA + int'(offset);
      @(negedge clk);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule